// File: doc/BRIEF.md
# Windowed Limit Comparator Interrupt Unit

This block sits behind a four-channel converter. Each time a channel delivers a fresh 10-bit result, the block compares the result's eight most significant bits with an 8-bit upper limit and an 8-bit lower limit held for that channel. A result above the upper limit sets that channel's sticky high flag. A result below the lower limit sets its sticky low flag.

The eight flags form one byte, with the low and high flags of each channel in adjacent bits. Software reads this byte through a read strobe, and the read clears every flag. The block drives a pull-down enable for a shared, active-low interrupt line. The line is pulled while any flag is set whose matching limit is non-zero, so a limit of zero disables that interrupt source. Limits are loaded through a small byte sequencer: a command picks the channel, then the upper limit byte and the lower limit byte follow in that order.

Top module: `limit_irq_unit`

## Requirements
- R1: There are four channels, each with an 8-bit upper and an 8-bit lower limit. Only sample bits [9:2] take part in the comparison, so the two least significant bits never change a result.
- R2: In a cycle where `sample_vld_i[c]` is high and bits [9:2] of channel c's sample are strictly greater than its upper limit, flag bit 2c+1 is set at that clock edge.
- R3: In a cycle where `sample_vld_i[c]` is high and bits [9:2] are strictly less than the lower limit, flag bit 2c is set at that clock edge. A value equal to a limit sets no flag.
- R4: A flag stays set until the flag byte is read.
- R5: At the edge where `flag_rd_i` is high, every flag bit clears. `flags_o` shows the pre-clear value during the read cycle.
- R6: A flag whose set condition occurs in the same cycle as a read is set after that edge.
- R7: `irq_pull_o` is 1 exactly when some flag bit is set whose limit (upper for odd bits, lower for even bits) is non-zero. A flag with a zero limit still sets but does not raise the interrupt.
- R8: A cycle with `lim_cmd_i` high selects channel `lim_ch_i`, and any byte in that cycle is ignored. The next `lim_byte_vld_i` byte loads the upper limit and the one after it loads the lower limit. Further bytes are ignored until the next command.
- R9: A sample whose valid bit is low has no effect on any flag.
- R10: After reset, all limits and flags are zero and `irq_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 40 | Four 10-bit samples; channel c in bits [10c+9:10c] |
| sample_vld_i | input | 4 | Per-channel sample strobe |
| lim_cmd_i | input | 1 | Start a limit write to channel `lim_ch_i` |
| lim_ch_i | input | 2 | Channel selected by the write command |
| lim_byte_vld_i | input | 1 | Limit data byte strobe |
| lim_byte_i | input | 8 | Limit data byte |
| flag_rd_i | input | 1 | Flag byte read strobe; clears all flags |
| flags_o | output | 8 | Flag byte; bit 2c low flag, bit 2c+1 high flag of channel c |
| irq_pull_o | output | 1 | 1 = pull the shared active-low interrupt line low |

## Verification
The bench puts samples exactly on a limit, one code step above it, and one code step below it. A design that compared with the wrong inequality or used the low sample bits would set flags at equality or fail to set them. Reads are issued in the same cycle as a qualifying sample, which catches a clear that swallows the new event. Zero limits are combined with triggering samples, which catches an interrupt that ignores the zero-disable rule. Extra limit bytes and samples with their valid bit low are sent, and the bench then probes the limits through later samples. A sequencer that keeps writing, or a comparator that ignores the strobe, shows up there as wrong flags.

// File: rtl/limit_irq_pkg.sv
// Shared types for the limit comparator interrupt unit.
package limit_irq_pkg;
    // Phase of the two-byte limit write sequence.
    typedef enum logic [1:0] {
        WR_IDLE  = 2'd0,
        WR_UPPER = 2'd1,
        WR_LOWER = 2'd2
    } wr_phase_t;
endpackage

// File: rtl/limit_reg_seq.sv
// Limit register file with a byte sequencer.
// A command selects a channel. The next byte loads that channel's upper
// limit and the byte after it loads the lower limit. Other bytes are dropped.
// Assumes command and data strobes are single-cycle pulses from the bus logic.
module limit_reg_seq
    import limit_irq_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int LIMIT_W = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_i,
    input  logic [CH_W-1:0]           ch_i,
    input  logic                      byte_vld_i,
    input  logic [LIMIT_W-1:0]        byte_i,
    output logic [NUM_CH*LIMIT_W-1:0] upper_o,
    output logic [NUM_CH*LIMIT_W-1:0] lower_o
);
    wr_phase_t       phase_q;
    logic [CH_W-1:0] ch_q;

    // Track which byte of the write sequence is expected next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= WR_IDLE;
            ch_q    <= '0;
        end else if (cmd_i) begin
            phase_q <= WR_UPPER;
            ch_q    <= ch_i;
        end else if (byte_vld_i) begin
            case (phase_q)
                WR_UPPER: phase_q <= WR_LOWER;
                default:  phase_q <= WR_IDLE;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lim
        // Load this channel's limits when its byte comes up.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                upper_o[c*LIMIT_W +: LIMIT_W] <= '0;
                lower_o[c*LIMIT_W +: LIMIT_W] <= '0;
            end else if (!cmd_i && byte_vld_i && ch_q == CH_W'(c)) begin
                if (phase_q == WR_UPPER)
                    upper_o[c*LIMIT_W +: LIMIT_W] <= byte_i;
                else if (phase_q == WR_LOWER)
                    lower_o[c*LIMIT_W +: LIMIT_W] <= byte_i;
            end
        end
    end

    // R8: an upper byte always moves the sequence on to the lower byte
    a_r8_upper_then_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !cmd_i && phase_q == WR_UPPER) |=> (phase_q == WR_LOWER));
    // R8: a command always restarts the sequence at the upper byte
    a_r8_cmd_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> (phase_q == WR_UPPER));
endmodule

// File: rtl/limit_chan_cmp.sv
// Window comparator for one channel.
// To compare only the top LIMIT_W sample bits, it compares the whole sample
// with the limit padded by ones (upper test) or zeros (lower test).
// A result is produced only while the channel's sample strobe is high.
module limit_chan_cmp #(
    parameter int SAMPLE_W = 10,
    parameter int LIMIT_W  = 8,
    localparam int PAD_W   = SAMPLE_W - LIMIT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                vld_i,
    input  logic [LIMIT_W-1:0]  upper_i,
    input  logic [LIMIT_W-1:0]  lower_i,
    output logic                hi_set_o,
    output logic                lo_set_o,
    output logic                hi_en_o,
    output logic                lo_en_o
);
    logic [SAMPLE_W-1:0] upper_pad;
    logic [SAMPLE_W-1:0] lower_pad;

    // Widen the limits so the whole sample can be compared directly.
    always_comb begin
        upper_pad = {upper_i, {PAD_W{1'b1}}};
        lower_pad = {lower_i, {PAD_W{1'b0}}};
    end

    // Detect excursions on a valid sample; a zero limit masks only the interrupt.
    always_comb begin
        hi_set_o = vld_i && (sample_i > upper_pad);
        lo_set_o = vld_i && (sample_i < lower_pad);
        hi_en_o  = (upper_i != '0);
        lo_en_o  = (lower_i != '0);
    end

    // R3: a zero lower limit can never report a low excursion
    a_r3_zero_lower_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_i == '0) |-> !lo_set_o);
endmodule

// File: rtl/flag_bank.sv
// Sticky flag register with clear-on-read.
// A read clears every bit at the edge. A set in the same cycle wins over
// the clear, so no event is lost.
module flag_bank #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 rd_i,
    output logic [NUM_FLAGS-1:0] flags_o
);
    // Accumulate flag events and drop the old ones on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_o <= '0;
        else
            flags_o <= (rd_i ? '0 : flags_o) | set_i;
    end

    // R5: a read with no new event leaves every flag clear
    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && set_i == '0) |=> (flags_o == '0));
    // R6: every event shows up after its edge, read or not
    a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    // R4: without a read, flags never drop
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/limit_irq_unit.sv
// Windowed limit comparator interrupt unit (top).
// Holds per-channel upper and lower limits and checks each valid sample
// against them. Sticky flags are kept in an interleaved byte: bit 2c is the
// low flag and bit 2c+1 the high flag of channel c. The unit asks the pad to
// pull the shared active-low interrupt line low while any flag with a
// non-zero limit is set. Assumes the pad provides the open-drain behaviour.
module limit_irq_unit #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 10,
    parameter int LIMIT_W  = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int FLAG_W  = 2 * NUM_CH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
    input  logic [NUM_CH-1:0]          sample_vld_i,
    input  logic                       lim_cmd_i,
    input  logic [CH_W-1:0]            lim_ch_i,
    input  logic                       lim_byte_vld_i,
    input  logic [LIMIT_W-1:0]         lim_byte_i,
    input  logic                       flag_rd_i,
    output logic [FLAG_W-1:0]          flags_o,
    output logic                       irq_pull_o
);
    logic [NUM_CH*LIMIT_W-1:0] upper;
    logic [NUM_CH*LIMIT_W-1:0] lower;
    logic [FLAG_W-1:0]         set_vec;
    logic [FLAG_W-1:0]         en_vec;

    limit_reg_seq #(.NUM_CH(NUM_CH), .LIMIT_W(LIMIT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (lim_cmd_i),
        .ch_i       (lim_ch_i),
        .byte_vld_i (lim_byte_vld_i),
        .byte_i     (lim_byte_i),
        .upper_o    (upper),
        .lower_o    (lower)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        limit_chan_cmp #(.SAMPLE_W(SAMPLE_W), .LIMIT_W(LIMIT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (sample_i[c*SAMPLE_W +: SAMPLE_W]),
            .vld_i    (sample_vld_i[c]),
            .upper_i  (upper[c*LIMIT_W +: LIMIT_W]),
            .lower_i  (lower[c*LIMIT_W +: LIMIT_W]),
            .hi_set_o (set_vec[2*c+1]),
            .lo_set_o (set_vec[2*c]),
            .hi_en_o  (en_vec[2*c+1]),
            .lo_en_o  (en_vec[2*c])
        );

        // R9: a flag can only rise after its channel delivered a valid sample
        a_r9_rise_needs_lo_sample: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[2*c]) |-> $past(sample_vld_i[c]));
        a_r9_rise_needs_hi_sample: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_o[2*c+1]) |-> $past(sample_vld_i[c]));
    end

    flag_bank #(.NUM_FLAGS(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .rd_i    (flag_rd_i),
        .flags_o (flags_o)
    );

    // Request the line pull-down for any enabled pending flag.
    always_comb irq_pull_o = |(flags_o & en_vec);

    // R7: the interrupt is never requested with no flag pending
    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o |-> (flags_o != '0));
endmodule

// File: tb/tb_limit_irq_unit.sv
// Self-checking bench: directed corners plus seeded random traffic, checked
// against a behavioural model built from the requirements.
module tb_limit_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [39:0] sample_i;
    logic [3:0]  sample_vld_i;
    logic        lim_cmd_i;
    logic [1:0]  lim_ch_i;
    logic        lim_byte_vld_i;
    logic [7:0]  lim_byte_i;
    logic        flag_rd_i;
    logic [7:0]  flags_o;
    logic        irq_pull_o;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [7:0] m_up [4];
    logic [7:0] m_lo [4];
    logic [7:0] m_flags;
    int         m_phase;
    int         m_ch;

    always #5 clk = ~clk;

    limit_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
        .lim_cmd_i(lim_cmd_i), .lim_ch_i(lim_ch_i), .lim_byte_vld_i(lim_byte_vld_i),
        .lim_byte_i(lim_byte_i), .flag_rd_i(flag_rd_i), .flags_o(flags_o),
        .irq_pull_o(irq_pull_o)
    );

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < 4; c++) begin
            r |= m_flags[2*c+1] && (m_up[c] != 8'd0);
            r |= m_flags[2*c]   && (m_lo[c] != 8'd0);
        end
        return r;
    endfunction

    task automatic check_out(input string req);
        n_chk++;
        if (flags_o !== m_flags) begin
            n_bad++;
            $display("FAIL %s flags: actual %02h expected %02h", req, flags_o, m_flags);
        end
        n_chk++;
        if (irq_pull_o !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq_pull_o, exp_irq());
        end
    endtask

    // One clock of stimulus; the model is updated and the outputs checked.
    task automatic step(input logic [3:0] vld, input logic [39:0] smp, input logic rd,
                        input logic cmd, input logic [1:0] ch, input logic bv,
                        input logic [7:0] b, input string req);
        logic [7:0] set = '0;
        sample_vld_i = vld; sample_i = smp; flag_rd_i = rd;
        lim_cmd_i = cmd; lim_ch_i = ch; lim_byte_vld_i = bv; lim_byte_i = b;
        for (int c = 0; c < 4; c++) begin
            if (vld[c]) begin
                if (smp[c*10+2 +: 8] > m_up[c]) set[2*c+1] = 1'b1;
                if (smp[c*10+2 +: 8] < m_lo[c]) set[2*c]   = 1'b1;
            end
        end
        @(negedge clk);
        m_flags = (rd ? 8'h00 : m_flags) | set;
        if (cmd) begin
            m_phase = 1; m_ch = int'(ch);
        end else if (bv) begin
            if (m_phase == 1) begin m_up[m_ch] = b; m_phase = 2; end
            else if (m_phase == 2) begin m_lo[m_ch] = b; m_phase = 0; end
        end
        sample_vld_i = '0; flag_rd_i = 1'b0; lim_cmd_i = 1'b0; lim_byte_vld_i = 1'b0;
        check_out(req);
    endtask

    task automatic write_lim(input logic [1:0] ch, input logic [7:0] up, input logic [7:0] lo);
        step('0, '0, 1'b0, 1'b1, ch, 1'b0, 8'h00, "R8");
        step('0, '0, 1'b0, 1'b0, 2'd0, 1'b1, up, "R8");
        step('0, '0, 1'b0, 1'b0, 2'd0, 1'b1, lo, "R8");
    endtask

    function automatic logic [39:0] put(input int ch, input logic [9:0] v);
        logic [39:0] r = '0;
        r[ch*10 +: 10] = v;
        return r;
    endfunction

    task automatic rd_flags(input string req);
        step('0, '0, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin m_up[c] = '0; m_lo[c] = '0; end
        m_flags = '0; m_phase = 0; m_ch = 0;
        rst_n = 1'b0; sample_i = '0; sample_vld_i = '0; lim_cmd_i = 1'b0; lim_ch_i = '0;
        lim_byte_vld_i = 1'b0; lim_byte_i = '0; flag_rd_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_out("R10");

        // R2/R3 boundaries on channel 0 (upper 100, lower 50)
        write_lim(2'd0, 8'd100, 8'd50);
        step(4'b0001, put(0, {8'd100, 2'b11}), 1'b0, 1'b0, 0, 1'b0, 0, "R1 R2 equal upper");
        step(4'b0001, put(0, {8'd50, 2'b00}), 1'b0, 1'b0, 0, 1'b0, 0, "R1 R3 equal lower");
        step(4'b0001, put(0, {8'd101, 2'b00}), 1'b0, 1'b0, 0, 1'b0, 0, "R2 above");
        step(4'b0001, put(0, {8'd49, 2'b11}), 1'b0, 1'b0, 0, 1'b0, 0, "R3 below");
        step('0, '0, 1'b0, 1'b0, 0, 1'b0, 0, "R4 sticky");
        rd_flags("R5 read clear");
        // R9: out-of-window samples without strobe
        step(4'b0000, put(0, 10'h3FF), 1'b0, 1'b0, 0, 1'b0, 0, "R9 no strobe");
        // R6: set in the read cycle survives
        step(4'b0001, put(0, 10'h3FF), 1'b0, 1'b0, 0, 1'b0, 0, "R6 pre");
        step(4'b0001, put(0, 10'h000), 1'b1, 1'b0, 0, 1'b0, 0, "R6 set with read");
        rd_flags("R5");
        // R7: zero limits flag but do not interrupt (channel 1 left at zero)
        step(4'b0010, put(1, 10'h3FF), 1'b0, 1'b0, 0, 1'b0, 0, "R7 zero upper");
        rd_flags("R7");
        // R8: byte in command cycle ignored, extra bytes ignored
        step('0, '0, 1'b0, 1'b1, 2'd2, 1'b1, 8'd7, "R8 cmd byte ignored");
        step('0, '0, 1'b0, 1'b0, 0, 1'b1, 8'd200, "R8 upper");
        step('0, '0, 1'b0, 1'b0, 0, 1'b1, 8'd20, "R8 lower");
        step('0, '0, 1'b0, 1'b0, 0, 1'b1, 8'd0, "R8 extra byte");
        step(4'b0100, put(2, {8'd19, 2'b00}), 1'b0, 1'b0, 0, 1'b0, 0, "R8 lower kept");
        step(4'b0100, put(2, {8'd201, 2'b00}), 1'b0, 1'b0, 0, 1'b0, 0, "R8 upper kept");
        rd_flags("R5");

        // Random traffic over all channels
        for (int i = 0; i < 1500; i++) begin
            int op = int'($urandom_range(0, 9));
            if (op == 0) begin
                write_lim(2'($urandom_range(0, 3)), 8'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                          8'($urandom_range(0, 3) == 0 ? 0 : $urandom));
            end else if (op == 1) begin
                step('0, '0, 1'b0, 1'b0, 0, 1'b1, 8'($urandom), "R8 stray byte");
            end else begin
                step(4'($urandom), {$urandom, 8'($urandom)}, ($urandom_range(0, 3) == 0),
                     1'b0, 0, 1'b0, 0, "R2 R3 R5 R6 R7 random");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule